// File: doc/BRIEF.md
# Four-Way Sub-Blocked Cache Tag Controller

This block holds the tags, per-sub-block present and dirty flags, and the replacement order for a small four-way set-associative cache of 4 KB. The cache has four sets of four blocks. A block covers 256 aligned bytes and is split into four 64-byte sub-blocks of sixteen 32-bit words. Each sub-block fills on its own. A miss brings in exactly one sub-block, so a block can be partly resident. The data RAMs and the engine that moves fill data are outside the block.

A lookup enters on a valid/ready request channel. Only one lookup is in flight at a time, and `req_ready` is high only while the controller is idle. If the addressed sub-block is resident, the controller answers one cycle after acceptance with the way and the on-chip cache RAM address. If it is not resident, the controller raises a fill request on a second valid/ready channel. That request carries the 64-byte-aligned address, the way to fill and, when a whole block is evicted, the dirty sub-blocks that must be written back first. The fill request holds steady until the engine accepts it. The cycle after acceptance, the lookup completes with `rsp_hit` low. The response is a one-cycle strobe with no back-pressure.

Each set keeps a full four-entry recency stack that runs from most to least recently used. Every completed lookup promotes its way to the top of that stack.

Top module: `cache_tag_ctrl`

## Requirements
- R1: The address splits as tag [31:10], set [9:8], sub-block [7:6], word [5:2] and byte [1:0]. `rsp_ram_addr` is the 12-bit concatenation {set, way, sub-block, word, byte}, with set in bits [11:10] and way in bits [9:8].
- R2: A lookup hits when a way in the addressed set has a matching tag, at least one present bit set, and the addressed sub-block's present bit set. On a hit, `rsp_valid` and `rsp_hit` are 1 in the cycle after acceptance, and no fill is requested.
- R3: A tag match whose addressed sub-block is not present is a sub-block miss. The fill request names the matching way and carries a write-back mask of 0. Other sub-blocks of that way stay present.
- R4: A lookup with no tag match is a block miss. It fills the least recently used way of the set. The fill clears all present bits of that way except the loaded sub-block, and `fill_addr` equals address bits [31:6].
- R5: A lookup with `req_write`=1 marks its sub-block dirty when it completes. On a block miss, `fill_wb_mask` gives the dirty sub-blocks of the evicted way (bit n = sub-block n), and `fill_wb_tag` gives that way's old tag. A sub-block miss reports a mask of 0. With `HAS_DIRTY`=0 the mask is always 0.
- R6: After reset every set's recency order is way 0 (most recent), then 1, 2, 3 (least recent). Each completed lookup moves its way to most recent, and the other ways keep their relative order. The four entries of a set are always distinct.
- R7: `fill_valid` stays high with stable `fill_addr`, `fill_way` and `fill_wb_mask` until `fill_ready`. The cycle after the handshake, `rsp_valid`=1 with `rsp_hit`=0, and the response carries the filled way.
- R8: `req_ready` is 1 only when no lookup is in flight. `rsp_valid` and `fill_valid` are never both high, and `rsp_valid` lasts one cycle per lookup.
- R9: After reset, `req_ready`=1, `rsp_valid`=0 and `fill_valid`=0, and no way of any set holds a present sub-block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Controller idle, lookup accepted |
| req_addr | input | 32 | Byte address to look up |
| req_write | input | 1 | Lookup is a store (marks dirty) |
| rsp_valid | output | 1 | Lookup completion strobe |
| rsp_hit | output | 1 | Completed without a fill |
| rsp_way | output | 2 | Way holding the sub-block |
| rsp_ram_addr | output | 12 | On-chip cache RAM byte address |
| fill_valid | output | 1 | Sub-block fill request valid |
| fill_ready | input | 1 | Fill engine has loaded the sub-block |
| fill_addr | output | 26 | 64-byte-aligned sub-block address (bits [31:6]) |
| fill_way | output | 2 | Way receiving the fill |
| fill_wb_mask | output | 4 | Dirty sub-blocks of the evicted way |
| fill_wb_tag | output | 22 | Tag of the evicted way |

## Verification
Some behaviour is checked by assertions on every cycle: the two handshake channels, including fill stability under back-pressure, the response that follows each fill, the exclusivity of response and fill, a write-back mask that appears only with a fill request, and the distinctness of each set's recency stack. The correctness of the replacement order can only be shown by bench scenarios. The same holds for the partial-block refill that keeps the other present bits, the dirty masks reported on eviction, and the RAM address arithmetic. The bench sweeps all sets, sub-blocks and a series of conflicting tags against its own reference model.

// File: rtl/cache_tag_pkg.sv
package cache_tag_pkg;
  // Associativity is fixed at four: the recency stack holds 2-bit way numbers.
  localparam int WAYS  = 4;
  localparam int WAY_W = 2;

  typedef logic [WAY_W-1:0] way_t;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_CHECK = 1'b1
  } ctl_state_e;
endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store
  import cache_tag_pkg::*;
#(
  parameter int SET_W     = 2,
  parameter int TAG_W     = 22,
  parameter int SUB_W     = 2,
  parameter bit HAS_DIRTY = 1'b1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [SET_W-1:0]                 set_idx,
  output logic [WAYS-1:0][TAG_W-1:0]       rd_tag,
  output logic [WAYS-1:0][(1<<SUB_W)-1:0]  rd_pres,
  output logic [WAYS-1:0][(1<<SUB_W)-1:0]  rd_dirty,
  input  logic                             fill_en,
  input  logic                             fill_alloc,
  input  way_t                             fill_way,
  input  logic [TAG_W-1:0]                 fill_tag,
  input  logic [SUB_W-1:0]                 fill_sub,
  input  logic                             mark_en,
  input  way_t                             mark_way,
  input  logic [SUB_W-1:0]                 mark_sub
);
  localparam int SETS = 1 << SET_W;
  localparam int SUBS = 1 << SUB_W;

  logic [TAG_W-1:0] tag_q  [SETS][WAYS];
  logic [SUBS-1:0]  pres_q [SETS][WAYS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          tag_q[s][w]  <= '0;
          pres_q[s][w] <= '0;
        end
      end
    end else if (fill_en) begin
      if (fill_alloc) begin
        tag_q[set_idx][fill_way]  <= fill_tag;
        pres_q[set_idx][fill_way] <= SUBS'(1) << fill_sub;
      end else begin
        pres_q[set_idx][fill_way][fill_sub] <= 1'b1;
      end
    end
  end

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      rd_tag[w]  = tag_q[set_idx][w];
      rd_pres[w] = pres_q[set_idx][w];
    end
  end

  generate
    if (HAS_DIRTY) begin : g_dirty
      logic [SUBS-1:0] dirty_q [SETS][WAYS];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) dirty_q[s][w] <= '0;
          end
        end else begin
          if (fill_en && fill_alloc) dirty_q[set_idx][fill_way] <= '0;
          if (mark_en) dirty_q[set_idx][mark_way][mark_sub] <= 1'b1;
        end
      end

      always_comb begin
        for (int w = 0; w < WAYS; w++) rd_dirty[w] = dirty_q[set_idx][w];
      end
    end else begin : g_nodirty
      logic unused_mark;
      assign unused_mark = ^{mark_en, mark_way, mark_sub};
      assign rd_dirty = '0;
    end
  endgenerate
endmodule

// File: rtl/cache_way_match.sv
module cache_way_match
  import cache_tag_pkg::*;
#(
  parameter int TAG_W = 22,
  parameter int SUB_W = 2
) (
  input  logic [WAYS-1:0][TAG_W-1:0]      tags,
  input  logic [WAYS-1:0][(1<<SUB_W)-1:0] pres,
  input  logic [TAG_W-1:0]                look_tag,
  input  logic [SUB_W-1:0]                look_sub,
  output logic                            tag_hit,
  output way_t                            hit_way,
  output logic                            sub_hit
);
  logic [WAYS-1:0] way_eq;

  generate
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign way_eq[w] = (tags[w] == look_tag) && (|pres[w]);
    end
  endgenerate

  always_comb begin
    tag_hit = 1'b0;
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (way_eq[w]) begin
        tag_hit = 1'b1;
        hit_way = way_t'(w);
      end
    end
    sub_hit = tag_hit && pres[hit_way][look_sub];
  end
endmodule

// File: rtl/cache_lru_stack.sv
module cache_lru_stack
  import cache_tag_pkg::*;
#(
  parameter int SET_W = 2
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [SET_W-1:0]                    set_idx,
  input  logic                                touch_en,
  input  way_t                                touch_way,
  output way_t                                victim,
  output logic [(1<<SET_W)*WAYS*WAY_W-1:0]    lru_flat
);
  localparam int SETS = 1 << SET_W;

  logic [SETS-1:0][WAYS-1:0][WAY_W-1:0] all_stk;

  generate
    for (genvar g = 0; g < SETS; g++) begin : g_set
      logic [WAYS-1:0][WAY_W-1:0] stk_q;
      logic [WAYS-1:0][WAY_W-1:0] stk_nxt;
      way_t                       pos;
      logic                       hit_here;

      assign hit_here = touch_en && (set_idx == SET_W'(g));

      always_comb begin
        pos = '0;
        for (int i = 0; i < WAYS; i++) begin
          if (stk_q[i] == touch_way) pos = way_t'(i);
        end
        stk_nxt[0] = touch_way;
        for (int i = 1; i < WAYS; i++) begin
          stk_nxt[i] = (way_t'(i) <= pos) ? stk_q[i-1] : stk_q[i];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < WAYS; i++) stk_q[i] <= way_t'(i);
        end else if (hit_here) begin
          stk_q <= stk_nxt;
        end
      end

      assign all_stk[g] = stk_q;
    end
  endgenerate

  assign victim   = all_stk[set_idx][WAYS-1];
  assign lru_flat = all_stk;
endmodule

// File: rtl/cache_tag_ctrl.sv
module cache_tag_ctrl
  import cache_tag_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int SET_W     = 2,
  parameter int SUB_W     = 2,
  parameter int WORD_W    = 4,
  parameter int BYTE_W    = 2,
  parameter bit HAS_DIRTY = 1'b1
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     req_valid,
  output logic                                     req_ready,
  input  logic [ADDR_W-1:0]                        req_addr,
  input  logic                                     req_write,
  output logic                                     rsp_valid,
  output logic                                     rsp_hit,
  output logic [WAY_W-1:0]                         rsp_way,
  output logic [SET_W+WAY_W+SUB_W+WORD_W+BYTE_W-1:0] rsp_ram_addr,
  output logic                                     fill_valid,
  input  logic                                     fill_ready,
  output logic [ADDR_W-WORD_W-BYTE_W-1:0]          fill_addr,
  output logic [WAY_W-1:0]                         fill_way,
  output logic [(1<<SUB_W)-1:0]                    fill_wb_mask,
  output logic [ADDR_W-SET_W-SUB_W-WORD_W-BYTE_W-1:0] fill_wb_tag
);
  localparam int OFF_W  = SUB_W + WORD_W + BYTE_W;
  localparam int TAG_W  = ADDR_W - SET_W - OFF_W;
  localparam int LINE_W = ADDR_W - WORD_W - BYTE_W;
  localparam int SUBS   = 1 << SUB_W;
  localparam int SETS   = 1 << SET_W;
  localparam int WB_W   = WORD_W + BYTE_W;

  ctl_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic              wr_q;
  logic              filled_q;

  logic [TAG_W-1:0]  a_tag;
  logic [SET_W-1:0]  a_set;
  logic [SUB_W-1:0]  a_sub;
  logic [WB_W-1:0]   a_wb;

  assign a_tag = addr_q[ADDR_W-1 -: TAG_W];
  assign a_set = addr_q[OFF_W +: SET_W];
  assign a_sub = addr_q[WB_W +: SUB_W];
  assign a_wb  = addr_q[WB_W-1:0];

  logic [WAYS-1:0][TAG_W-1:0] rd_tag;
  logic [WAYS-1:0][SUBS-1:0]  rd_pres;
  logic [WAYS-1:0][SUBS-1:0]  rd_dirty;
  logic                       tag_hit;
  logic                       sub_hit;
  way_t                       hit_way;
  way_t                       victim;
  logic [SETS*WAYS*WAY_W-1:0] lru_flat;

  logic in_check;
  logic hit_now;
  logic fill_fire;
  logic mark_en;

  assign in_check  = (state_q == ST_CHECK);
  assign hit_now   = sub_hit;
  assign fill_fire = fill_valid && fill_ready;
  assign mark_en   = rsp_valid && wr_q;

  cache_tag_store #(
    .SET_W(SET_W), .TAG_W(TAG_W), .SUB_W(SUB_W), .HAS_DIRTY(HAS_DIRTY)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_idx   (a_set),
    .rd_tag    (rd_tag),
    .rd_pres   (rd_pres),
    .rd_dirty  (rd_dirty),
    .fill_en   (fill_fire),
    .fill_alloc(!tag_hit),
    .fill_way  (fill_way),
    .fill_tag  (a_tag),
    .fill_sub  (a_sub),
    .mark_en   (mark_en),
    .mark_way  (hit_way),
    .mark_sub  (a_sub)
  );

  cache_way_match #(.TAG_W(TAG_W), .SUB_W(SUB_W)) u_match (
    .tags    (rd_tag),
    .pres    (rd_pres),
    .look_tag(a_tag),
    .look_sub(a_sub),
    .tag_hit (tag_hit),
    .hit_way (hit_way),
    .sub_hit (sub_hit)
  );

  cache_lru_stack #(.SET_W(SET_W)) u_lru (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_idx  (a_set),
    .touch_en (rsp_valid),
    .touch_way(hit_way),
    .victim   (victim),
    .lru_flat (lru_flat)
  );

  // Request side
  assign req_ready = (state_q == ST_IDLE);

  // Completion side
  assign rsp_valid    = in_check && hit_now;
  assign rsp_hit      = !filled_q;
  assign rsp_way      = hit_way;
  assign rsp_ram_addr = {a_set, hit_way, a_sub, a_wb};

  // Fill side
  assign fill_valid   = in_check && !hit_now;
  assign fill_addr    = addr_q[ADDR_W-1:WB_W];
  assign fill_way     = tag_hit ? hit_way : victim;
  assign fill_wb_mask = (fill_valid && !tag_hit) ? rd_dirty[victim] : '0;
  assign fill_wb_tag  = rd_tag[victim];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      wr_q     <= 1'b0;
      filled_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            state_q  <= ST_CHECK;
            addr_q   <= req_addr;
            wr_q     <= req_write;
            filled_q <= 1'b0;
          end
        end
        ST_CHECK: begin
          if (hit_now)        state_q  <= ST_IDLE;
          else if (fill_ready) filled_q <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cache_tag_chk.sv
module cache_tag_chk
  import cache_tag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SET_W  = 2,
  parameter int SUB_W  = 2,
  parameter int WORD_W = 4,
  parameter int BYTE_W = 2
) (
  input logic                                  clk,
  input logic                                  rst_n,
  input logic                                  req_ready,
  input logic                                  rsp_valid,
  input logic                                  rsp_hit,
  input logic                                  fill_valid,
  input logic                                  fill_ready,
  input logic [ADDR_W-WORD_W-BYTE_W-1:0]       fill_addr,
  input logic [WAY_W-1:0]                      fill_way,
  input logic [(1<<SUB_W)-1:0]                 fill_wb_mask,
  input logic [(1<<SET_W)*WAYS*WAY_W-1:0]      lru_flat
);
  localparam int SETS = 1 << SET_W;

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!rsp_valid && !fill_valid));

  assert_one_outcome_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_valid, fill_valid}));

  assert_rsp_then_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (req_ready && !rsp_valid));

  assert_fill_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !fill_ready) |=>
      (fill_valid && $stable(fill_addr) && $stable(fill_way) && $stable(fill_wb_mask)));

  assert_fill_then_rsp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && fill_ready) |=> (rsp_valid && !rsp_hit));

  assert_wb_with_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_wb_mask != '0) |-> fill_valid);

  generate
    for (genvar s = 0; s < SETS; s++) begin : g_lru
      logic [WAYS-1:0] seen;
      always_comb begin
        seen = '0;
        for (int i = 0; i < WAYS; i++)
          seen[lru_flat[(s*WAYS+i)*WAY_W +: WAY_W]] = 1'b1;
      end
      assert_lru_distinct_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(seen) == WAYS);
    end
  endgenerate
endmodule

bind cache_tag_ctrl cache_tag_chk #(
  .ADDR_W(ADDR_W), .SET_W(SET_W), .SUB_W(SUB_W), .WORD_W(WORD_W), .BYTE_W(BYTE_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .rsp_valid   (rsp_valid),
  .rsp_hit     (rsp_hit),
  .fill_valid  (fill_valid),
  .fill_ready  (fill_ready),
  .fill_addr   (fill_addr),
  .fill_way    (fill_way),
  .fill_wb_mask(fill_wb_mask),
  .lru_flat    (lru_flat)
);

// File: tb/tb_cache_tag_ctrl.sv
`timescale 1ns/1ps
module tb_cache_tag_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        rsp_valid;
  logic        rsp_hit;
  logic [1:0]  rsp_way;
  logic [11:0] rsp_ram_addr;
  logic        fill_valid;
  logic        fill_ready = 1'b0;
  logic [25:0] fill_addr;
  logic [1:0]  fill_way;
  logic [3:0]  fill_wb_mask;
  logic [21:0] fill_wb_tag;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  cache_tag_ctrl dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way), .rsp_ram_addr(rsp_ram_addr),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_addr(fill_addr),
    .fill_way(fill_way), .fill_wb_mask(fill_wb_mask), .fill_wb_tag(fill_wb_tag)
  );

  // Reference model built from the requirements
  logic [21:0] m_tag   [4][4];
  logic [3:0]  m_pres  [4][4];
  logic [3:0]  m_dirty [4][4];
  int          m_lru   [4][4];

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_touch(input int s, input int w);
    int pos = 0;
    for (int i = 0; i < 4; i++) if (m_lru[s][i] == w) pos = i;
    for (int i = pos; i > 0; i--) m_lru[s][i] = m_lru[s][i-1];
    m_lru[s][0] = w;
  endtask

  task automatic access(input logic [31:0] a, input logic wr, input int dly);
    int s  = int'(a[9:8]);
    int sb = int'(a[7:6]);
    logic [21:0] t = a[31:10];
    int mw = -1;
    int ew;
    logic [3:0] ewb;
    bit hit;
    for (int w = 0; w < 4; w++)
      if (m_pres[s][w] != 0 && m_tag[s][w] == t) mw = w;
    hit = (mw >= 0) && m_pres[s][mw][sb];

    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = wr;
    chk("R8", "req_ready idle", 32'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8", "req_ready busy", 32'(req_ready), 0);
    if (hit) begin
      ew = mw;
      chk("R2", "rsp_valid", 32'(rsp_valid), 1);
      chk("R2", "rsp_hit", 32'(rsp_hit), 1);
      chk("R2", "no fill", 32'(fill_valid), 0);
    end else begin
      ew  = (mw >= 0) ? mw : m_lru[s][3];
      ewb = (mw >= 0) ? 4'h0 : m_dirty[s][ew];
      chk("R7", "fill_valid", 32'(fill_valid), 1);
      chk("R8", "rsp_valid during fill", 32'(rsp_valid), 0);
      chk(mw >= 0 ? "R3" : "R4", "fill_way", 32'(fill_way), 32'(ew));
      chk("R4", "fill_addr", 32'(fill_addr), 32'(a[31:6]));
      chk(mw >= 0 ? "R3" : "R5", "fill_wb_mask", 32'(fill_wb_mask), 32'(ewb));
      if (ewb != 0) chk("R5", "fill_wb_tag", 32'(fill_wb_tag), 32'(m_tag[s][ew]));
      for (int d = 0; d < dly; d++) begin
        @(negedge clk);
        chk("R7", "fill held", 32'(fill_valid), 1);
        chk("R7", "fill_addr held", 32'(fill_addr), 32'(a[31:6]));
        chk("R7", "fill_way held", 32'(fill_way), 32'(ew));
      end
      fill_ready = 1'b1;
      @(negedge clk);
      fill_ready = 1'b0;
      chk("R7", "rsp after fill", 32'(rsp_valid), 1);
      chk("R7", "rsp_hit after fill", 32'(rsp_hit), 0);
      if (mw < 0) begin
        m_tag[s][ew]   = t;
        m_pres[s][ew]  = 4'b1 << sb;
        m_dirty[s][ew] = 4'h0;
      end else begin
        m_pres[s][ew][sb] = 1'b1;
      end
    end
    chk("R6", "rsp_way", 32'(rsp_way), 32'(ew));
    chk("R1", "rsp_ram_addr", 32'(rsp_ram_addr), 32'({a[9:8], 2'(ew), a[7:0]}));
    if (wr) m_dirty[s][ew][sb] = 1'b1;
    model_touch(s, ew);
  endtask

  function automatic logic [31:0] mk_addr(input int tg, input int s, input int sb, input int wd, input int by);
    logic [21:0] t = 22'(tg * 32'h1234 + 7);
    return {t, 2'(s), 2'(sb), 4'(wd), 2'(by)};
  endfunction

  initial begin
    for (int s = 0; s < 4; s++)
      for (int w = 0; w < 4; w++) begin
        m_tag[s][w] = '0; m_pres[s][w] = '0; m_dirty[s][w] = '0; m_lru[s][w] = w;
      end
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9", "req_ready", 32'(req_ready), 1);
    chk("R9", "rsp_valid", 32'(rsp_valid), 0);
    chk("R9", "fill_valid", 32'(fill_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", "req_ready after release", 32'(req_ready), 1);
    // R9/R4: tag 0 at address 0 must still miss; first victim is way 3 (R6)
    access(32'h0, 1'b0, 0);
    access(32'h0, 1'b0, 0);

    // Sweep: six conflicting tags per set, every sub-block, mixed writes
    for (int tg = 1; tg <= 6; tg++)
      for (int s = 0; s < 4; s++)
        for (int sb = 0; sb < 4; sb++)
          access(mk_addr(tg, s, sb, (sb * 3 + tg) % 16, tg % 4),
                 (sb == 1) || (tg == 2) || (tg == 5 && sb == 3), (tg + sb) % 3);

    // Re-touch in a scrambled order to move ways around the middle of the stack
    for (int r = 0; r < 3; r++)
      for (int s = 0; s < 4; s++)
        for (int k = 0; k < 6; k++) begin
          int tg = ((k * 5 + r + s) % 6) + 1;
          access(mk_addr(tg, s, (k + r) % 4, k, r), (k % 2 == 0), k % 2);
        end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule